// File: doc/BRIEF.md
# 100Base-X Receive Code-Group Aligner

This block takes a serial stream of 5-bit code-group bits, one bit per clock, that has already been NRZI-decoded and descrambled but carries no knowledge of where code-groups begin. It hunts for the start-of-stream delimiter pair at any bit offset. Once it finds the pair, it fixes the group boundary for the rest of the frame. It then slices every following group on that boundary and translates it to a 4-bit nibble. The nibble is presented MII-style with a one-cycle strobe and level outputs for data-valid, carrier-sense and receive-error.

A frame ends on the end-of-stream pair or on an idle group. Alignment is dropped then, and the next frame is hunted from scratch. Sometimes activity appears on the line but the delimiter pair does not follow. The block then reports a bad start: it keeps emitting error nibbles on the boundary it guessed, until two idle groups arrive back to back.

Top module: `symbol_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `nib_stb`, `rx_dv`, `rx_crs`, `rx_er` and `nib` all at 0.
- R2: A stream of only one-bits (idle, group code 11111) produces no strobe, and `rx_crs` stays 0.
- R3: The pair J = 11000 then K = 10001 (bits listed first-received first) is found at any bit offset. On the edge that samples the last K bit, the outputs show exactly one strobe, with `nib` = 0101, `rx_crs` = 1 and `rx_dv` = 0. No strobe occurs during the J and K bits before that edge.
- R4: After lock, every fifth bit completes a group. A data group is decoded per the 4B/5B table (0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101). It is presented with a strobe on the edge sampling its last bit, with `rx_dv` = 1 and `rx_er` = 0.
- R5: A group inside a frame that is neither data, idle nor T gives a strobe with `nib` = 0000, `rx_dv` = 1 and `rx_er` = 1. The next valid data group clears `rx_er`.
- R6: The group T = 01101 drops `rx_dv` with no strobe on the edge sampling its last bit. The group after it (normally R = 00111) is consumed with no strobe, and `rx_crs` falls on its last bit. The next frame is re-aligned at its own offset.
- R7: An idle group inside a frame ends it at once: no strobe, and `rx_dv`, `rx_crs` and `rx_er` fall on the edge sampling its last bit.
- R8: When hunting, the first zero bit opens a check. The zero is taken as the third bit of J, so the check happens once seven more bits are in. If the ten-bit window then is not J,K but holds at least two zeros, that edge gives a strobe with `nib` = 1110, `rx_er` = 1, `rx_crs` = 1 and `rx_dv` = 0. Every later group on that boundary does the same.
- R9: The bad-start error persists through a single idle group, which still strobes 1110. It clears only on the second of two consecutive idle groups. That group gives no strobe and drops `rx_er` and `rx_crs`.
- R10: A zero that has no second zero within the checked ten-bit window is ignored. There is no strobe and `rx_crs` stays 0, and hunting resumes so that a later J,K still locks.
- R11: `rx_dv` is never 1 while `rx_crs` is 0, and two strobes are never on adjacent clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one code bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Serial code bit, descrambled, NRZ |
| nib_stb | output | 1 | One-cycle pulse: a new nibble is on `nib` |
| nib | output | 4 | Decoded nibble (preamble 0101, error 1110/0000) |
| rx_dv | output | 1 | Frame data is valid |
| rx_crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error |

## Verification
The hardest state to reach is the bad-start error held across a lone idle group. To get there, a zero must arrive while hunting, the window must hold a second zero without matching the delimiter, and then an idle group must be followed by a non-idle group before the closing idle pair. The bench builds exactly that group sequence: two J-like groups, a data group, one idle, a data group, then two idles. It also sends frames whose leading idle runs cover every bit offset modulo five, so that lock is seen from each starting phase.

// File: rtl/symalign_pkg.sv
// Package: shared constants, state type and the 4B/5B code table for the
// receive code-group aligner. Groups are written first-received bit at MSB.
package symalign_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int WIN_W = 2 * SYM_W;
    localparam int NUM_DATA = 1 << NIB_W;

    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_BAD  = 4'b1110;
    localparam logic [NIB_W-1:0] NIB_INV  = 4'b0000;

    // Ones of J received before its first zero bit.
    localparam int J_LEAD_ONES = 2;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SEEK,
        ST_FRAME,
        ST_TAIL,
        ST_BAD
    } align_state_e;

    typedef struct packed {
        logic              hit;
        logic [NIB_W-1:0]  nib;
        logic              idle;
        logic              term;
    } grp_info_t;

    // Five-bit data code for a nibble value.
    function automatic logic [SYM_W-1:0] code_of(input logic [NIB_W-1:0] n);
        logic [SYM_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bit_window.sv
// Module: bit_window
// Shifts the serial bit into a window, newest bit at bit 0. Also exposes the
// window as it will be after this clock, so decisions line up with the edge
// that samples the bit. Assumes one valid bit per clock; resets to all ones
// (idle) so no spurious zero appears.
module bit_window #(
    parameter int WIN = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_in,
    output logic [WIN-1:0] win_q,
    output logic [WIN-1:0] win_nx
);

    // Next-window view: every stage takes its younger neighbour.
    assign win_nx[0] = bit_in;
    for (genvar g = 1; g < WIN; g++) begin : g_stage
        assign win_nx[g] = win_q[g-1];
    end

    // Window register, cleared to idle ones.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_nx;
    end

endmodule

// File: rtl/group_decoder.sv
// Module: group_decoder
// Combinational classification of one 5-bit group: data hit and nibble,
// idle, or end-of-stream T. Assumes the group's first-received bit is MSB.
module group_decoder
    import symalign_pkg::*;
(
    input  logic [SYM_W-1:0] grp,
    output grp_info_t        info
);

    logic [NUM_DATA-1:0] match;

    // One comparator per data code.
    for (genvar g = 0; g < NUM_DATA; g++) begin : g_cmp
        assign match[g] = (grp == code_of(NIB_W'(g)));
    end

    // Fold the one-hot match into a nibble.
    always_comb begin
        info.nib = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (match[i]) info.nib = info.nib | NIB_W'(i);
        end
        info.hit  = |match;
        info.idle = (grp == SYM_IDLE);
        info.term = (grp == SYM_T);
    end

endmodule

// File: rtl/align_ctrl.sv
// Module: align_ctrl
// Alignment state machine and registered MII-style outputs. It hunts for a
// zero, checks the ten-bit window for J,K once the pair would be complete,
// then slices groups every SYM_W bits until T or idle ends the frame. A
// carrier without the delimiter enters a held error state that clears after
// IDLE_CLR consecutive idle groups. Assumes win_nx/info describe the bits
// as of the current edge.
module align_ctrl
    import symalign_pkg::*;
#(
    parameter int IDLE_CLR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [WIN_W-1:0] win_nx,
    input  grp_info_t        info,
    output logic             nib_stb,
    output logic [NIB_W-1:0] nib,
    output logic             rx_dv,
    output logic             rx_crs,
    output logic             rx_er
);

    localparam int SEEK_LAST = WIN_W - J_LEAD_ONES - 2;
    localparam int CNT_W     = $clog2(WIN_W);
    localparam int RUN_W     = $clog2(IDLE_CLR + 1);
    localparam logic [WIN_W-1:0] JK_PAT = {SYM_J, SYM_K};

    align_state_e     st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             stb_d, dv_d, crs_d, er_d;
    logic [NIB_W-1:0] nib_d;
    logic             grp_done;
    logic             two_zeros;

    assign grp_done  = (cnt_q == CNT_W'(SYM_W - 1));
    assign two_zeros = ($countones(~win_nx) >= 2);

    // Next-state and output decisions for the current bit.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        run_d = run_q;
        stb_d = 1'b0;
        nib_d = nib;
        dv_d  = rx_dv;
        crs_d = rx_crs;
        er_d  = rx_er;
        case (st_q)
            ST_HUNT: begin
                if (!bit_in) begin
                    st_d  = ST_SEEK;
                    cnt_d = '0;
                end
            end
            ST_SEEK: begin
                if (cnt_q == CNT_W'(SEEK_LAST)) begin
                    cnt_d = '0;
                    if (win_nx == JK_PAT) begin
                        st_d  = ST_FRAME;
                        stb_d = 1'b1;
                        nib_d = NIB_PRE;
                        dv_d  = 1'b0;
                        crs_d = 1'b1;
                        er_d  = 1'b0;
                    end else if (two_zeros) begin
                        st_d  = ST_BAD;
                        run_d = '0;
                        stb_d = 1'b1;
                        nib_d = NIB_BAD;
                        dv_d  = 1'b0;
                        crs_d = 1'b1;
                        er_d  = 1'b1;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FRAME: begin
                cnt_d = grp_done ? '0 : cnt_q + 1'b1;
                if (grp_done) begin
                    if (info.term) begin
                        st_d = ST_TAIL;
                        dv_d = 1'b0;
                        er_d = 1'b0;
                    end else if (info.idle) begin
                        st_d  = ST_HUNT;
                        dv_d  = 1'b0;
                        crs_d = 1'b0;
                        er_d  = 1'b0;
                    end else if (info.hit) begin
                        stb_d = 1'b1;
                        nib_d = info.nib;
                        dv_d  = 1'b1;
                        er_d  = 1'b0;
                    end else begin
                        stb_d = 1'b1;
                        nib_d = NIB_INV;
                        dv_d  = 1'b1;
                        er_d  = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                cnt_d = grp_done ? '0 : cnt_q + 1'b1;
                if (grp_done) begin
                    st_d  = ST_HUNT;
                    dv_d  = 1'b0;
                    crs_d = 1'b0;
                    er_d  = 1'b0;
                end
            end
            ST_BAD: begin
                cnt_d = grp_done ? '0 : cnt_q + 1'b1;
                if (grp_done) begin
                    if (info.idle && run_q == RUN_W'(IDLE_CLR - 1)) begin
                        st_d  = ST_HUNT;
                        run_d = '0;
                        crs_d = 1'b0;
                        er_d  = 1'b0;
                    end else begin
                        stb_d = 1'b1;
                        nib_d = NIB_BAD;
                        er_d  = 1'b1;
                        run_d = info.idle ? run_q + 1'b1 : '0;
                    end
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            cnt_q   <= '0;
            run_q   <= '0;
            nib_stb <= 1'b0;
            nib     <= '0;
            rx_dv   <= 1'b0;
            rx_crs  <= 1'b0;
            rx_er   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            run_q   <= run_d;
            nib_stb <= stb_d;
            nib     <= nib_d;
            rx_dv   <= dv_d;
            rx_crs  <= crs_d;
            rx_er   <= er_d;
        end
    end

endmodule

// File: rtl/symbol_aligner.sv
// Module: symbol_aligner (top)
// Serial 100Base-X receive aligner: bit window, group classifier on the
// newest five bits, and the alignment controller. Assumes one code bit per
// clock, already descrambled and NRZ.
module symbol_aligner
    import symalign_pkg::*;
#(
    parameter int IDLE_CLR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    output logic             nib_stb,
    output logic [NIB_W-1:0] nib,
    output logic             rx_dv,
    output logic             rx_crs,
    output logic             rx_er
);

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_nx;
    grp_info_t        info;

    bit_window #(.WIN(WIN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (rx_bit),
        .win_q  (win_q),
        .win_nx (win_nx)
    );

    group_decoder u_dec (
        .grp  (win_nx[SYM_W-1:0]),
        .info (info)
    );

    align_ctrl #(.IDLE_CLR(IDLE_CLR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rx_bit),
        .win_nx  (win_nx),
        .info    (info),
        .nib_stb (nib_stb),
        .nib     (nib),
        .rx_dv   (rx_dv),
        .rx_crs  (rx_crs),
        .rx_er   (rx_er)
    );

endmodule

// File: rtl/symbol_aligner_chk.sv
// Module: symbol_aligner_chk
// Port-level properties of the aligner, bound onto every instance.
module symbol_aligner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_stb,
    input logic [3:0] nib,
    input logic       rx_dv,
    input logic       rx_crs,
    input logic       rx_er
);

    a_r11_dv_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> rx_crs);

    a_r11_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> !nib_stb);

    a_r8_bad_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && rx_er && !rx_dv) |-> (nib == 4'b1110));

    a_r4_dv_rise_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> nib_stb);

    a_r6_crs_fall_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_crs) |-> (!rx_dv && !rx_er && !nib_stb));

    a_r3_preamble_code: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && !rx_dv && !rx_er) |-> (nib == 4'b0101));

endmodule

bind symbol_aligner symbol_aligner_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib_stb (nib_stb),
    .nib     (nib),
    .rx_dv   (rx_dv),
    .rx_crs  (rx_crs),
    .rx_er   (rx_er)
);

// File: tb/symbol_aligner_tb.sv
// Bench for symbol_aligner: a vector table of frames at varied bit offsets,
// then directed tests for reset, errors, bad start and stray zeros.
module symbol_aligner_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b1;
    logic       nib_stb;
    logic [3:0] nib;
    logic       rx_dv, rx_crs, rx_er;

    int n_tests = 0;
    int n_fail  = 0;
    int stb_cnt = 0;
    int dv_wo_crs = 0;
    logic [3:0] last_nib = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    symbol_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .nib_stb(nib_stb), .nib(nib),
        .rx_dv(rx_dv), .rx_crs(rx_crs), .rx_er(rx_er)
    );

    // Frames: {leading ones, first data nibble, second data nibble}.
    localparam int NVEC = 6;
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd10, 4'h3, 4'hC}, {5'd11, 4'h0, 4'hF}, {5'd12, 4'h7, 4'h8},
        {5'd13, 4'hA, 4'h5}, {5'd14, 4'h1, 4'hE}, {5'd17, 4'h9, 4'h2}
    };

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
        if (nib_stb) begin
            stb_cnt++;
            last_nib = nib;
        end
        if (rx_dv && !rx_crs) dv_wo_crs++;
    endtask

    task automatic send_sym(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_jk();
        stb_cnt = 0;
        send_sym(5'b11000);
        send_sym(5'b10001);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk({nib_stb, nib, rx_dv, rx_crs, rx_er} == '0, "R1 reset outputs",
            {nib_stb, nib, rx_dv, rx_crs, rx_er}, 0);
        rst_n = 1'b1;

        // R2: idle stream
        stb_cnt = 0;
        send_ones(40);
        chk(stb_cnt == 0 && !rx_crs, "R2 idle no strobe", stb_cnt, 0);

        // R3 R4 R6: table of frames at all bit offsets
        for (int v = 0; v < NVEC; v++) begin
            send_ones(int'(VEC[v][12:8]));
            send_jk();
            chk(stb_cnt == 1 && last_nib == 4'b0101, "R3 preamble on lock",
                {stb_cnt[3:0], last_nib}, 8'h15);
            chk(rx_crs && !rx_dv, "R3 crs up dv low", {rx_crs, rx_dv}, 2'b10);
            stb_cnt = 0;
            send_sym(enc(VEC[v][7:4]));
            chk(stb_cnt == 1 && last_nib == VEC[v][7:4] && rx_dv && !rx_er,
                "R4 data nibble a", last_nib, VEC[v][7:4]);
            stb_cnt = 0;
            send_sym(enc(VEC[v][3:0]));
            chk(stb_cnt == 1 && last_nib == VEC[v][3:0] && rx_dv,
                "R4 data nibble b", last_nib, VEC[v][3:0]);
            stb_cnt = 0;
            send_sym(5'b01101);
            chk(stb_cnt == 0 && !rx_dv && rx_crs, "R6 T drops dv",
                {stb_cnt[3:0], rx_dv, rx_crs}, 1);
            send_sym(5'b00111);
            chk(stb_cnt == 0 && !rx_crs, "R6 R drops crs", {stb_cnt[3:0], rx_crs}, 0);
        end

        // R5: invalid group in frame, then recovery
        send_ones(12);
        send_jk();
        stb_cnt = 0;
        send_sym(5'b00000);
        chk(stb_cnt == 1 && last_nib == 4'b0000 && rx_er && rx_dv,
            "R5 invalid group", {last_nib, rx_er, rx_dv}, 6'b000011);
        stb_cnt = 0;
        send_sym(enc(4'h6));
        chk(stb_cnt == 1 && last_nib == 4'h6 && !rx_er, "R5 er clears",
            {last_nib, rx_er}, 5'b01100);
        send_sym(5'b01101);
        send_sym(5'b00111);

        // R7: idle group ends frame
        send_ones(13);
        send_jk();
        send_sym(enc(4'hB));
        stb_cnt = 0;
        send_sym(5'b11111);
        chk(stb_cnt == 0 && !rx_dv && !rx_crs && !rx_er, "R7 idle ends frame",
            {stb_cnt[3:0], rx_dv, rx_crs, rx_er}, 0);

        // R8 R9: bad start, held through a single idle
        send_ones(11);
        stb_cnt = 0;
        send_sym(5'b11000);
        send_sym(5'b11000);
        chk(stb_cnt == 1 && last_nib == 4'b1110 && rx_er && rx_crs && !rx_dv,
            "R8 bad start", {last_nib, rx_er, rx_crs, rx_dv}, 7'b1110110);
        stb_cnt = 0;
        send_sym(enc(4'h3));
        chk(stb_cnt == 1 && last_nib == 4'b1110 && rx_er, "R8 error per group",
            {last_nib, rx_er}, 5'b11101);
        stb_cnt = 0;
        send_sym(5'b11111);
        chk(stb_cnt == 1 && rx_er && rx_crs, "R9 one idle keeps error",
            {stb_cnt[3:0], rx_er, rx_crs}, 6'b000111);
        send_sym(enc(4'h4));
        stb_cnt = 0;
        send_sym(5'b11111);
        chk(stb_cnt == 1 && rx_er, "R9 idle run restarted", {stb_cnt[3:0], rx_er}, 5'b00011);
        stb_cnt = 0;
        send_sym(5'b11111);
        chk(stb_cnt == 0 && !rx_er && !rx_crs, "R9 two idles clear",
            {stb_cnt[3:0], rx_er, rx_crs}, 0);

        // R10: stray single zero ignored, then a frame still locks
        send_ones(10);
        stb_cnt = 0;
        send_sym(5'b11011);
        send_ones(15);
        chk(stb_cnt == 0 && !rx_crs && !rx_er, "R10 stray zero ignored",
            {stb_cnt[3:0], rx_crs, rx_er}, 0);
        send_ones(3);
        send_jk();
        chk(stb_cnt == 1 && last_nib == 4'b0101 && rx_crs, "R10 hunt resumes",
            {stb_cnt[3:0], last_nib}, 8'h15);
        send_sym(5'b01101);
        send_sym(5'b00111);

        // R1: reset mid-frame clears outputs
        send_ones(10);
        send_jk();
        send_sym(enc(4'hD));
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk({nib_stb, rx_dv, rx_crs, rx_er} == '0, "R1 reset mid-frame",
            {nib_stb, rx_dv, rx_crs, rx_er}, 0);
        rst_n = 1'b1;

        // R11: dv never seen without crs
        chk(dv_wo_crs == 0, "R11 dv implies crs", dv_wo_crs, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule